// File: doc/BRIEF.md
# UART receive framer with resynchronisation

This block turns an asynchronous serial line into characters. A sample-enable tick arrives at sixteen times the bit rate, and the block uses it to find a start bit, centre on each bit, and shift in a data character of five to eight bits, least significant bit first. Configuration inputs select the data length, whether a parity bit follows, even or odd parity, and one or two stop bits. For each character the block raises a one-clock valid strobe. The strobe comes with the right-aligned data byte, a parity-error flag, a framing-error flag and a break flag.

When the stop bit is sampled low, the block reports a framing error. It then assumes that the low level was really the start bit of the next character. It samples the line once more one tick later. If the line is still low, it shifts in the next character's data bits at the normal spacing, without waiting for a fresh falling edge. If the line has returned high, it goes back to idle.

The serial input is assumed to be already synchronous to the clock. Baud-rate generation, character storage and software access sit outside this block.

Top module: `uart_rx_framer`

## Requirements
- R1: In idle, a tick with the line low starts a candidate start bit. The candidate is accepted only if the line is still low on the 8th tick after that one. Otherwise the block returns to idle and produces no character.
- R2: The data length is given by cfg_len: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. out_data holds them right-aligned, and bits at or above the data length are 0.
- R3: After the start-bit midpoint, each later bit is sampled once, 16 ticks after the previous sample. Clock edges without tick do not advance the receiver.
- R4: With cfg_par_en=1, one parity bit follows the data. With cfg_par_even=1, the data bits plus the parity bit must hold an even number of ones; with cfg_par_even=0, an odd number. A mismatch sets out_perr. With cfg_par_en=0, out_perr is always 0.
- R5: out_ferr is set when the first stop bit, the bit after the last data or parity bit, is sampled as 0.
- R6: With cfg_two_stop=1, the second stop bit is never checked. The line is ignored until the end of that second bit, so a low second stop bit yields neither an error nor a new character.
- R7: out_brk is set when the data bits, the parity bit (when enabled) and the first stop bit are all 0. A break therefore always comes with out_ferr=1 and out_data=0.
- R8: After a framing error the line is sampled again one tick after the stop sample. If it is still low, data bits are sampled from 16 ticks after the stop sample, with no new falling edge. If it is high, the block returns to idle.
- R9: out_valid is high for exactly one clock per character: the clock, on a tick, that samples the first stop bit. out_data and the flags change only on that clock and hold in between.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_len | input | 2 | Data length code: 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| cfg_two_stop | input | 1 | Two stop bits (second unchecked) |
| out_valid | output | 1 | One-clock character strobe |
| out_data | output | 8 | Received data, right-aligned |
| out_perr | output | 1 | Parity error for this character |
| out_ferr | output | 1 | Framing error for this character |
| out_brk | output | 1 | Break detected |

## Verification
The assertions check, on every clock, the rules that tie the outputs to each other:
- the strobe is a single clock long and falls only on a tick;
- the outputs hold between strobes;
- a break comes with a framing error and zero data;
- bits above the data length are zero;
- no parity error is reported while parity is off.

Only the bench's scenarios can show the timing-dependent behaviour: rejection of a short start glitch, stalling without ticks, blanking of a low second stop bit, and the two outcomes of resynchronisation after a bad stop bit. The same holds for exact data and parity values across configurations.

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_two_stop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_perr,
  output logic       out_ferr,
  output logic       out_brk
);
  localparam int HALF = OS / 2;
  localparam int CW = $clog2(OS + HALF);
  localparam logic [CW-1:0] C_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] C_FULL = CW'(OS - 1);
  localparam logic [CW-1:0] C_TAIL = CW'(OS + HALF - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_RESYNC
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    shreg;
  logic          pbit;

  logic [2:0] last_bit;
  logic [7:0] aligned;
  logic       at_full;

  assign last_bit = 3'(cfg_len) + 3'd4;
  assign aligned  = shreg >> (3'd7 - last_bit);
  assign at_full  = (cnt == C_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      nbit      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_brk   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rxd) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == C_HALF) begin
              st   <= rxd ? S_IDLE : S_DATA;
              cnt  <= '0;
              nbit <= '0;
              pbit <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (at_full) begin
              cnt   <= '0;
              shreg <= {rxd, shreg[7:1]};
              nbit  <= nbit + 1'b1;
              if (nbit == last_bit) st <= cfg_par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (at_full) begin
              cnt  <= '0;
              pbit <= rxd;
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (at_full) begin
              cnt       <= '0;
              out_valid <= 1'b1;
              out_data  <= aligned;
              out_perr  <= cfg_par_en & (^aligned ^ pbit ^ ~cfg_par_even);
              out_ferr  <= ~rxd;
              out_brk   <= ~rxd & (aligned == 8'd0) & ~pbit;
              if (!rxd)              st <= S_RESYNC;
              else if (cfg_two_stop) st <= S_STOP2;
              else                   st <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP2: begin
            if (cnt == C_TAIL) st <= S_IDLE;
            else               cnt <= cnt + 1'b1;
          end
          S_RESYNC: begin
            if (!rxd) begin
              st   <= S_DATA;
              cnt  <= CW'(1);
              nbit <= '0;
              pbit <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_rx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] cfg_len,
  input logic       cfg_par_en,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_perr,
  input logic       out_ferr,
  input logic       out_brk
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r9_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tick));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_perr) && $stable(out_ferr) && $stable(out_brk)));
  a_r7_brk_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_brk) |-> (out_ferr && out_data == 8'd0));
  a_r4_no_perr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_par_en) |-> !out_perr);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (4'(cfg_len) + 4'd5)) == 8'd0));
  always_comb begin
    if (!rst_n) a_r10_reset: assert (!out_valid && !out_ferr && !out_brk);
  end
endmodule

bind uart_rx_framer uart_rx_framer_chk i_chk (.*);

// File: tb/test_uart_rx_framer.sv
`timescale 1ns/1ps
module test_uart_rx_framer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
  logic out_valid, out_perr, out_ferr, out_brk;
  logic [7:0] out_data;

  uart_rx_framer i_uart_rx_framer (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, nval = 0;
  logic [7:0] log_d [64];
  logic log_p [64], log_f [64], log_b [64];

  always @(negedge clk) if (out_valid && nval < 64) begin
    log_d[nval] = out_data; log_p[nval] = out_perr;
    log_f[nval] = out_ferr; log_b[nval] = out_brk;
    nval = nval + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_out(input logic v, input int n);
    repeat (n) begin
      @(negedge clk); rxd = v; tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic send(input logic [1:0] len, input logic pen, input logic even, input logic two,
                      input logic [7:0] din, input logic bad, input logic stop_v, input int stop_ticks);
    logic x = 1'b0;
    cfg_len = len; cfg_par_en = pen; cfg_par_even = even; cfg_two_stop = two;
    tick_out(1'b0, 16);
    for (int i = 0; i < int'(len) + 5; i++) begin
      x ^= din[i];
      tick_out(din[i], 16);
    end
    if (pen) tick_out(x ^ ~even ^ bad, 16);
    tick_out(stop_v, stop_ticks);
  endtask

  typedef struct packed {
    logic [1:0] len; logic pen; logic even; logic two; logic bad;
    logic [7:0] din; logic [7:0] exp_d; logic exp_p;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h35, 8'h15, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h41, 8'h41, 1'b1},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2B, 8'h2B, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && out_data == 0 && out_perr == 0 && out_ferr == 0 && out_brk == 0,
        "R10 reset outputs", {out_valid, out_perr, out_ferr, out_brk}, 0);
    rst_n = 1'b1;
    tick_out(1'b1, 20);

    foreach (VEC[k]) begin
      base = nval;
      send(VEC[k].len, VEC[k].pen, VEC[k].even, VEC[k].two, VEC[k].din, VEC[k].bad, 1'b1, 16);
      tick_out(1'b1, 32);
      chk(nval == base + 1, "R9 one strobe per frame", nval - base, 1);
      chk(log_d[base] == VEC[k].exp_d, "R2 data", log_d[base], VEC[k].exp_d);
      chk(log_p[base] == VEC[k].exp_p, "R4 parity flag", log_p[base], VEC[k].exp_p);
      chk(log_f[base] == 0 && log_b[base] == 0, "R5 no ferr/brk on good stop",
          {log_f[base], log_b[base]}, 0);
    end

    base = nval;
    tick_out(1'b0, 5); tick_out(1'b1, 40);
    chk(nval == base, "R1 short start glitch rejected", nval - base, 0);

    base = nval;
    @(negedge clk); rxd = 1'b0;
    repeat (100) @(negedge clk);
    tick_out(1'b1, 40);
    chk(nval == base, "R3 no progress without tick", nval - base, 0);

    base = nval;
    send(2'd3, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 16);
    tick_out(1'b0, 16); tick_out(1'b1, 40);
    chk(nval == base + 1, "R6 low second stop ignored", nval - base, 1);
    chk(log_d[base] == 8'h5A && log_f[base] == 0, "R6 data and no ferr", log_d[base], 8'h5A);

    base = nval;
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 16);
    for (int i = 0; i < 8; i++) tick_out(logic'(8'h3C >> i), 16);
    tick_out(1'b1, 40);
    chk(nval == base + 2, "R8 resync yields second char", nval - base, 2);
    chk(log_d[base] == 8'h96 && log_f[base] == 1 && log_b[base] == 0, "R5 ferr on low stop",
        {log_d[base], log_f[base], log_b[base]}, {8'h96, 1'b1, 1'b0});
    chk(log_d[base+1] == 8'h3C && log_f[base+1] == 0, "R8 resync data",
        log_d[base+1], 8'h3C);

    base = nval;
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 9);
    tick_out(1'b1, 40);
    chk(nval == base + 1, "R8 line high at resample returns to idle", nval - base, 1);
    chk(log_f[base] == 1, "R5 ferr before abort", log_f[base], 1);

    base = nval;
    send(2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 9);
    tick_out(1'b1, 40);
    chk(nval == base + 1, "R7 break strobe count", nval - base, 1);
    chk(log_b[base] == 1 && log_f[base] == 1 && log_p[base] == 0 && log_d[base] == 0,
        "R7 break flags", {log_b[base], log_f[base], log_p[base]}, 3'b110);

    base = nval;
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 9);
    tick_out(1'b1, 40);
    chk(nval == base + 1 && log_b[base] == 0 && log_f[base] == 1,
        "R7 parity bit high is not break", {log_b[base], log_f[base]}, 2'b01);

    chk(out_valid == 0, "R9 strobe low when idle", out_valid, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule